// File: doc/BRIEF.md
# Key-Protected System Clock Divider

This block turns a root clock into a slower timing reference for the digital logic around it. It produces two outputs. The first is a one-cycle enable strobe that fires once every N root cycles. The second is a registered square-ish level that runs at the same divided rate. The ratio N comes from a 6-bit field in a 16-bit configuration register, which sits on a simple single-cycle write bus with a combinational read port.

The configuration register is guarded. A write to it lands only when the unlock value 0xA815 has just been written to a companion key register. Each unlock covers a single configuration write. Any other key value, or a completed configuration write, closes the guard again.

The stored field is turned into an effective ratio before use:

- 0 is treated as 1.
- Anything above 32 is treated as 32.

A new ratio is picked up only when the divider reaches the end of its current period, so the output never shows a shortened period.

Top module: `sysclk_divider`

## Requirements
- R1: After reset the configuration field reads 1. The strobe is high in every cycle and the level output is high.
- R2: A read at word address 0 returns the raw stored 6-bit field in bits [5:0] and zero in bits [15:6]. The raw value is returned, so 0 reads as 0 and 50 reads as 50, not the clamped ratio.
- R3: A write to the configuration register (word address 0) while the guard is closed is ignored, and the stored field keeps its value.
- R4: Writing 0xA815 to the key register (word address 1) opens the guard for exactly one configuration write. A second configuration write after that is ignored.
- R5: Writing any value other than 0xA815 to the key register closes an open guard.
- R6: With a field value N from 2 to 32, the strobe is high for one cycle in every N cycles.
- R7: A field value of 0 gives ratio 1, so the strobe is high in every cycle.
- R8: A field value above 32 gives ratio 32.
- R9: A new ratio takes effect only at the divider's terminal count, and the period in progress completes at the old length. A configuration write captured on the same edge as a terminal count takes effect one full period later.
- R10: In each period of ratio N, the level output is high for the first ceil(N/2) cycles after a strobe and low for the rest. With N=1 it stays high.
- R11: A read at word address 1 (the key register) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request, taken on the rising clock edge |
| bus_addr | input | 2 | Word address: 0 selects configuration, 1 selects key |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| div_stb | output | 1 | One-cycle enable strobe at the end of each period |
| div_clk | output | 1 | Registered divided-clock level |

## Verification
The collision of interest is a configuration write and a terminal count on the same clock edge. On that edge the counter reloads its ratio, and the register takes its new value. The bench waits until the strobe is observed, and then drives the write so that it is captured on that exact edge. It then judges that the following period still has the old length and that the one after it has the new length. A reference model checks strobe and level in every cycle throughout the run, so the same collision is also judged wherever the sequence produces it by chance.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Bus data width and the width of the stored ratio field
  localparam int unsigned REG_W      = 16;
  localparam int unsigned FIELD_W    = 6;
  // Largest effective division ratio
  localparam int unsigned MAX_RATIO  = 32;
  // Value that opens the write guard for one configuration write
  localparam logic [REG_W-1:0] UNLOCK_VAL = 16'hA815;
  // Word addresses on the register bus
  localparam int unsigned ADDR_W     = 2;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 2'd0;
  localparam logic [ADDR_W-1:0] KEY_ADDR = 2'd1;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int unsigned DW      = REG_W,
  parameter int unsigned FW      = FIELD_W,
  parameter int unsigned AW      = ADDR_W,
  parameter logic [DW-1:0] KEY   = UNLOCK_VAL,
  parameter logic [AW-1:0] A_CFG = CFG_ADDR,
  parameter logic [AW-1:0] A_KEY = KEY_ADDR,
  parameter logic [FW-1:0] RST_FIELD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [FW-1:0] field,
  output logic          armed
);
  logic          arm_d, arm_q;
  logic [FW-1:0] fld_d, fld_q;
  logic          key_hit, cfg_hit, fld_en;

  always_comb begin
    key_hit = wr && (addr == A_KEY);
    cfg_hit = wr && (addr == A_CFG);
    fld_en  = cfg_hit && arm_q;
    // guard: a key write sets or clears it, a config write always clears it
    if (key_hit)      arm_d = (wdata == KEY);
    else if (cfg_hit) arm_d = 1'b0;
    else              arm_d = arm_q;
    fld_d = fld_en ? wdata[FW-1:0] : fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      fld_q <= RST_FIELD;
    end else begin
      arm_q <= arm_d;
      fld_q <= fld_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CFG) rdata[FW-1:0] = fld_q;
  end

  assign field = fld_q;
  assign armed = arm_q;
endmodule

// File: rtl/clkdiv_clamp.sv
module clkdiv_clamp #(
  parameter int unsigned FW  = 6,
  parameter int unsigned MAX = 32,
  parameter int unsigned RW  = $clog2(MAX + 1)
) (
  input  logic [FW-1:0] raw,
  output logic [RW-1:0] ratio
);
  localparam logic [FW-1:0] MAX_F = FW'(MAX);

  always_comb begin
    if (raw == '0)       ratio = RW'(1);
    else if (raw > MAX_F) ratio = RW'(MAX);
    else                 ratio = RW'(raw);
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int unsigned MAX   = 32,
  parameter int unsigned RW    = $clog2(MAX + 1),
  parameter int unsigned CNT_W = (MAX > 1) ? $clog2(MAX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RW-1:0]    ratio_in,
  output logic             stb,
  output logic             lvl,
  output logic [CNT_W-1:0] cnt,
  output logic [RW-1:0]    ratio_act
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic [RW-1:0]    n_d, n_q;
  logic [RW-1:0]    half_d;
  logic             lvl_d, lvl_q;
  logic             term;

  always_comb begin
    term   = (RW'(cnt_q) == (n_q - RW'(1)));
    // the ratio is reloaded only at the end of a period
    cnt_d  = term ? '0 : cnt_q + CNT_W'(1);
    n_d    = term ? ratio_in : n_q;
    half_d = (n_d + RW'(1)) >> 1;
    lvl_d  = (RW'(cnt_d) < half_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      n_q   <= RW'(1);
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      n_q   <= n_d;
      lvl_q <= lvl_d;
    end
  end

  assign stb       = term;
  assign lvl       = lvl_q;
  assign cnt       = cnt_q;
  assign ratio_act = n_q;
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import clkdiv_pkg::*;
#(
  parameter int unsigned DW      = REG_W,
  parameter int unsigned FW      = FIELD_W,
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned MAX_DIV = MAX_RATIO,
  parameter logic [DW-1:0] KEY   = UNLOCK_VAL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          div_stb,
  output logic          div_clk
);
  localparam int unsigned RW    = $clog2(MAX_DIV + 1);
  localparam int unsigned CNT_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [FW-1:0]    cfg_q;
  logic             arm_q;
  logic [RW-1:0]    ratio_pend;
  logic [RW-1:0]    n_act_q;
  logic [CNT_W-1:0] cnt_q;

  clkdiv_regs #(
    .DW(DW), .FW(FW), .AW(AW), .KEY(KEY),
    .A_CFG(CFG_ADDR), .A_KEY(KEY_ADDR), .RST_FIELD(FW'(1))
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .field(cfg_q), .armed(arm_q)
  );

  clkdiv_clamp #(.FW(FW), .MAX(MAX_DIV), .RW(RW)) u_clamp (
    .raw(cfg_q), .ratio(ratio_pend)
  );

  clkdiv_core #(.MAX(MAX_DIV), .RW(RW), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .ratio_in(ratio_pend),
    .stb(div_stb), .lvl(div_clk), .cnt(cnt_q), .ratio_act(n_act_q)
  );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
  parameter int unsigned FW    = 6,
  parameter int unsigned AW    = 2,
  parameter int unsigned MAX   = 32,
  parameter int unsigned RW    = 6,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic [AW-1:0]    addr,
  input logic             arm,
  input logic [FW-1:0]    cfg,
  input logic [CNT_W-1:0] cnt,
  input logic [RW-1:0]    n_act,
  input logic             stb,
  input logic             lvl
);
  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(cfg));

  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == AW'(0)) |=> !arm);

  // R8
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_act != '0) && (n_act <= RW'(MAX)));

  // R9
  ratio_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(n_act));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    RW'(cnt) < n_act);

  // R10
  level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && n_act > RW'(1)) |-> !lvl);
endmodule

bind sysclk_divider clkdiv_chk #(
  .FW(FW), .AW(AW), .MAX(MAX_DIV), .RW(RW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .arm(arm_q),
  .cfg(cfg_q), .cnt(cnt_q), .n_act(n_act_q), .stb(div_stb), .lvl(div_clk)
);

// File: tb/sysclk_divider_tb.sv
module sysclk_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        div_stb, div_clk;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int        m_cnt = 0;
  int        m_n   = 1;
  int        m_cfg = 1;
  bit        m_arm = 1'b0;
  bit        mon_en = 1'b0;
  bit        rd_req = 1'b0;
  logic [15:0] exp_q[$];
  string     rd_tag;

  always #4 clk = ~clk;  // 125 MHz

  sysclk_divider u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div_stb(div_stb), .div_clk(div_clk)
  );

  function automatic int eff_ratio(int v);
    if (v == 0) return 1;
    if (v > 32) return 32;
    return v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: counter uses the old field, then the bus is applied
  always @(posedge clk) begin
    if (rst_n) begin
      if (m_cnt == m_n - 1) begin
        m_cnt = 0;
        m_n   = eff_ratio(m_cfg);
      end else m_cnt++;
      if (bus_wr) begin
        if (bus_addr == 2'd1) m_arm = (bus_wdata == 16'hA815);
        else if (bus_addr == 2'd0) begin
          if (m_arm) m_cfg = bus_wdata[5:0];
          m_arm = 1'b0;
        end
      end
    end
  end

  // monitor: compares every cycle, pops queued read expectations
  always @(posedge clk) begin
    #7;
    if (mon_en) begin
      check(div_stb == (m_cnt == m_n - 1), "R6 strobe vs model", div_stb, m_cnt == m_n - 1);
      check(div_clk == (m_cnt < (m_n + 1) / 2), "R10 level vs model", div_clk, m_cnt < (m_n + 1) / 2);
    end
    if (rd_req) begin
      logic [15:0] e;
      e = exp_q.pop_front();
      check(bus_rdata == e, rd_tag, bus_rdata, e);
    end
  end

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic bus_write(logic [1:0] a, logic [15:0] d);
    step();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, logic [15:0] e, string tag);
    step();
    bus_addr = a;
    exp_q.push_back(e);
    rd_tag = tag;
    rd_req = 1'b1;
    step();
    rd_req = 1'b0;
  endtask

  task automatic wait_stb();
    step();
    while (!div_stb) step();
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      step();
      bus_wr = 1'b0;
      n++;
    end while (!div_stb && n < 100);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, hi;
    #20;
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(div_stb == 1'b1, "R1 strobe after reset", div_stb, 1);
    check(div_clk == 1'b1, "R1 level after reset", div_clk, 1);
    mon_en = 1'b1;
    bus_read(2'd0, 16'd1, "R1 field after reset");
    // R11 key register reads zero
    bus_write(2'd1, 16'hA815);
    bus_read(2'd1, 16'd0, "R11 key reads zero");
    bus_write(2'd0, 16'd4);                    // consumes the guard
    bus_read(2'd0, 16'd4, "R4 guarded write lands");
    // R3 write with guard closed
    bus_write(2'd0, 16'd9);
    bus_read(2'd0, 16'd4, "R3 and R4 second write ignored");
    // R5 wrong key closes guard
    bus_write(2'd1, 16'hA815);
    bus_write(2'd1, 16'hA814);
    bus_write(2'd0, 16'd7);
    bus_read(2'd0, 16'd4, "R5 wrong key closes guard");
    // R6 ratio 4
    wait_stb(); measure(n); measure(n);
    check(n == 4, "R6 period ratio 4", n, 4);
    // R10 ratio 5 level shape
    bus_write(2'd1, 16'hA815);
    bus_write(2'd0, 16'd5);
    wait_stb(); wait_stb();
    hi = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (div_clk) hi++;
    end
    check(hi == 3, "R10 high cycles ratio 5", hi, 3);
    // R9 write captured on a terminal-count edge
    bus_write(2'd1, 16'hA815);
    wait_stb();
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'd8;
    measure(n);
    check(n == 5, "R9 old period completes", n, 5);
    measure(n);
    check(n == 8, "R9 new ratio after terminal", n, 8);
    // R7 field 0
    bus_write(2'd1, 16'hA815);
    bus_write(2'd0, 16'd0);
    bus_read(2'd0, 16'd0, "R2 raw zero read");
    wait_stb(); measure(n); measure(n);
    check(n == 1, "R7 zero acts as one", n, 1);
    // R8 field above 32
    bus_write(2'd1, 16'hA815);
    bus_write(2'd0, 16'd50);
    bus_read(2'd0, 16'd50, "R2 raw 50 read");
    wait_stb(); measure(n); measure(n);
    check(n == 32, "R8 saturates to 32", n, 32);
    // R2 reserved bits
    bus_write(2'd1, 16'hA815);
    bus_write(2'd0, 16'hFFC3);
    bus_read(2'd0, 16'h0003, "R2 reserved bits zero");
    wait_stb(); measure(n); measure(n);
    check(n == 3, "R6 period ratio 3", n, 3);
    repeat (10) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule